// File: doc/BRIEF.md
# Integer ALU with Overflow Traps

This block is the combinational integer execution stage of a 32-bit load-store RISC core. In a single evaluation it takes two register operands, a 16-bit immediate, a constant shift count and an operation code, and returns a full-width result together with an overflow-trap flag. The supported operations are:

- add and subtract, each in a trapping and a non-trapping form;
- the four bitwise operations, AND, OR, XOR and NOR;
- signed and unsigned set-less-than;
- left, logical right and arithmetic right shifts, either by the constant count or by a count taken from a register;
- placing the immediate in the upper half of the word.

Immediate forms widen the 16-bit field first. The widening is with zeros or with the sign bit, depending on whether the operation is bitwise or arithmetic.

When a trapping operation overflows, the block still drives the wrapped two's-complement value on the result. It also raises a write-suppress output, so that the surrounding pipeline can cancel the register write and take the exception. The block does not route exceptions anywhere and does not multiply, divide or touch memory.

Top module: `int_exec_unit`

## Requirements
- R1: For operation codes 0 (add, trapping), 2 (subtract, trapping) and 10 (add immediate, trapping), the result is the wrapped sum or difference, and `ovf_o` is 1 exactly when the signed result overflows. For add, overflow means both operands share a sign and the result has the other sign. Subtract applies the same rule to a minus b.
- R2: Operation codes 1 (add), 3 (subtract) and 11 (add immediate) give the wrapped result and never raise `ovf_o`.
- R3: Every operation other than codes 0, 2 and 10 leaves `ovf_o` at 0.
- R4: Codes 14 (AND imm), 15 (OR imm) and 16 (XOR imm) zero-extend the immediate to 32 bits before combining it with `src_a_i`.
- R5: Codes 10, 11, 12 (signed less-than imm) and 13 (unsigned less-than imm) sign-extend the immediate to 32 bits.
- R6: Codes 8 (register) and 12 (immediate) compare as two's-complement values. The result is 1 if `src_a_i` is less than the second operand and 0 otherwise, with bits 31:1 always zero.
- R7: Codes 9 (register) and 13 (immediate) perform the same comparison on unsigned values.
- R8: Codes 4, 5, 6 and 7 return `src_a_i` AND, OR, XOR and NOR `src_b_i` respectively. NOR is the inverse of the OR.
- R9: Codes 18, 19 and 20 shift `src_a_i` by `shamt_i`:
  - 18 shifts left, filling with zeros;
  - 19 shifts right, filling with zeros;
  - 20 shifts right, filling with copies of bit 31.
  `src_b_i` has no effect on these codes.
- R10: Codes 21, 22 and 23 shift `src_a_i` left, right logically and right arithmetically. The count is bits 4:0 of `src_b_i`; the upper bits of `src_b_i` and all of `shamt_i` are ignored.
- R11: Code 17 returns the immediate in bits 31:16 and zeros in bits 15:0.
- R12: `wr_suppress_o` equals `ovf_o` for every operation.
- R13: Codes 24 to 31 are reserved and return an all-zero result with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (see requirements) |
| src_a_i | input | 32 | First register operand; value shifted by all shifts |
| src_b_i | input | 32 | Second register operand; count source for variable shifts |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Constant shift count |
| result_o | output | 32 | Operation result, all bits written |
| ovf_o | output | 1 | Signed overflow on a trapping operation |
| wr_suppress_o | output | 1 | Request to cancel the destination write |

## Verification
The bound checker evaluates several properties on every change of the inputs:
- the overflow flag agrees with the sign relation among the operands and the result on trapping adds and subtracts;
- the flag stays low everywhere else;
- set-less-than results are strictly 0 or 1;
- the upper-immediate result has the required layout;
- reserved codes produce zero.

The directed scenarios are needed for the rest. They show the actual values of extension, comparison and shifting:
- zero versus sign fill;
- signed versus unsigned ordering of the same bit patterns;
- that only the low five bits of the register count are used;
- that the unused count source has no effect.

// File: rtl/int_exec_pkg.sv
// Shared definitions for the integer execution unit.
// Assumes a 5-bit operation code; codes 24..31 are reserved.
package int_exec_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADDU  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBU  = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_NOR   = 5'd7,
        OP_SLT   = 5'd8,
        OP_SLTU  = 5'd9,
        OP_ADDI  = 5'd10,
        OP_ADDIU = 5'd11,
        OP_SLTI  = 5'd12,
        OP_SLTIU = 5'd13,
        OP_ANDI  = 5'd14,
        OP_ORI   = 5'd15,
        OP_XORI  = 5'd16,
        OP_LUI   = 5'd17,
        OP_SLL   = 5'd18,
        OP_SRL   = 5'd19,
        OP_SRA   = 5'd20,
        OP_SLLV  = 5'd21,
        OP_SRLV  = 5'd22,
        OP_SRAV  = 5'd23
    } op_e;

    // Which functional unit feeds the result.
    typedef enum logic [3:0] {
        SEL_ZERO,
        SEL_ARITH,
        SEL_AND,
        SEL_OR,
        SEL_XOR,
        SEL_NOR,
        SEL_SLT,
        SEL_SLTU,
        SEL_SHIFT,
        SEL_UPPER
    } sel_e;

    // Decoded control bundle.
    typedef struct packed {
        sel_e sel;
        logic use_imm;     // second operand from the immediate
        logic imm_signed;  // sign-extend instead of zero-extend
        logic subtract;    // adder computes a - b
        logic trap;        // signed overflow is reported
        logic sh_var;      // shift count from src_b
        logic sh_right;    // shift right instead of left
        logic sh_arith;    // right shift fills with the sign bit
    } ctl_t;

endpackage

// File: rtl/int_exec_opnd.sv
// Second-operand selector: passes the register operand, or widens the
// immediate with zeros or sign copies. Assumes DATA_W > IMM_W.
module int_exec_opnd #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] reg_b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    input  logic              imm_signed_i,
    output logic [DATA_W-1:0] opnd_o
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic             fill;
    logic [DATA_W-1:0] imm_wide;

    // Widen the immediate and pick the operand.
    always_comb begin
        fill     = imm_signed_i & imm_i[IMM_W-1];
        imm_wide = {{PAD_W{fill}}, imm_i};
        opnd_o   = use_imm_i ? imm_wide : reg_b_i;
    end
endmodule

// File: rtl/int_exec_arith.sv
// Adder/subtractor with signed-overflow detection and both orderings of
// the less-than comparison. The comparison outputs are meaningful only
// when subtract_i is high.
module int_exec_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              subtract_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              sovf_o,
    output logic              lt_signed_o,
    output logic              lt_unsigned_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    // One carry chain serves add, subtract and both comparisons.
    always_comb begin
        b_eff         = subtract_i ? ~b_i : b_i;
        wide          = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, subtract_i};
        sum_o         = wide[MSB:0];
        sovf_o        = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
        lt_signed_o   = sum_o[MSB] ^ sovf_o;
        lt_unsigned_o = ~wide[DATA_W];
    end
endmodule

// File: rtl/int_exec_shift.sv
// Logarithmic barrel shifter. Left shifts reuse the right-shift network
// through bit reversal. Assumes DATA_W is a power of two.
module int_exec_shift #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         val_i,
    input  logic [$clog2(DATA_W)-1:0] amt_i,
    input  logic                      right_i,
    input  logic                      arith_i,
    output logic [DATA_W-1:0]         res_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] stage [SH_W+1];
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] rev_out;
    logic              fill;

    // Reverse bit order for left shifts; fill only for arithmetic right.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            rev_in[i] = val_i[DATA_W-1-i];
        end
        fill     = right_i & arith_i & val_i[DATA_W-1];
        stage[0] = right_i ? val_i : rev_in;
    end

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int K = 2 ** s;
        // Stage s moves the word right by 2**s when its count bit is set.
        always_comb begin
            stage[s+1] = amt_i[s] ? {{K{fill}}, stage[s][DATA_W-1:K]} : stage[s];
        end
    end

    // Undo the reversal for left shifts.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            rev_out[i] = stage[SH_W][DATA_W-1-i];
        end
        res_o = right_i ? stage[SH_W] : rev_out;
    end
endmodule

// File: rtl/int_exec_unit.sv
// Integer execution unit: decodes the operation, routes operands through
// the operand selector, adder and shifter, and selects the result.
// Purely combinational; the overflow flag doubles as the write-suppress
// request and the result always carries the wrapped value.
module int_exec_unit #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int OPC_W  = 5
) (
    input  logic [OPC_W-1:0]          op_i,
    input  logic [DATA_W-1:0]         src_a_i,
    input  logic [DATA_W-1:0]         src_b_i,
    input  logic [IMM_W-1:0]          imm_i,
    input  logic [$clog2(DATA_W)-1:0] shamt_i,
    output logic [DATA_W-1:0]         result_o,
    output logic                      ovf_o,
    output logic                      wr_suppress_o
);
    import int_exec_pkg::*;

    localparam int SH_W  = $clog2(DATA_W);
    localparam int LOW_W = DATA_W - IMM_W;

    ctl_t              ctl;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] sum;
    logic              sovf;
    logic              lt_s;
    logic              lt_u;
    logic [SH_W-1:0]   sh_amt;
    logic [DATA_W-1:0] sh_res;

    // Decode the operation code into the control bundle.
    always_comb begin
        ctl = '{sel: SEL_ZERO, default: 1'b0};
        unique case (op_i)
            OP_ADD:   begin ctl.sel = SEL_ARITH; ctl.trap = 1'b1; end
            OP_ADDU:  ctl.sel = SEL_ARITH;
            OP_SUB:   begin ctl.sel = SEL_ARITH; ctl.subtract = 1'b1; ctl.trap = 1'b1; end
            OP_SUBU:  begin ctl.sel = SEL_ARITH; ctl.subtract = 1'b1; end
            OP_AND:   ctl.sel = SEL_AND;
            OP_OR:    ctl.sel = SEL_OR;
            OP_XOR:   ctl.sel = SEL_XOR;
            OP_NOR:   ctl.sel = SEL_NOR;
            OP_SLT:   begin ctl.sel = SEL_SLT;  ctl.subtract = 1'b1; end
            OP_SLTU:  begin ctl.sel = SEL_SLTU; ctl.subtract = 1'b1; end
            OP_ADDI:  begin
                ctl.sel = SEL_ARITH; ctl.use_imm = 1'b1;
                ctl.imm_signed = 1'b1; ctl.trap = 1'b1;
            end
            OP_ADDIU: begin ctl.sel = SEL_ARITH; ctl.use_imm = 1'b1; ctl.imm_signed = 1'b1; end
            OP_SLTI:  begin
                ctl.sel = SEL_SLT; ctl.use_imm = 1'b1;
                ctl.imm_signed = 1'b1; ctl.subtract = 1'b1;
            end
            OP_SLTIU: begin
                ctl.sel = SEL_SLTU; ctl.use_imm = 1'b1;
                ctl.imm_signed = 1'b1; ctl.subtract = 1'b1;
            end
            OP_ANDI:  begin ctl.sel = SEL_AND; ctl.use_imm = 1'b1; end
            OP_ORI:   begin ctl.sel = SEL_OR;  ctl.use_imm = 1'b1; end
            OP_XORI:  begin ctl.sel = SEL_XOR; ctl.use_imm = 1'b1; end
            OP_LUI:   ctl.sel = SEL_UPPER;
            OP_SLL:   ctl.sel = SEL_SHIFT;
            OP_SRL:   begin ctl.sel = SEL_SHIFT; ctl.sh_right = 1'b1; end
            OP_SRA:   begin ctl.sel = SEL_SHIFT; ctl.sh_right = 1'b1; ctl.sh_arith = 1'b1; end
            OP_SLLV:  begin ctl.sel = SEL_SHIFT; ctl.sh_var = 1'b1; end
            OP_SRLV:  begin ctl.sel = SEL_SHIFT; ctl.sh_var = 1'b1; ctl.sh_right = 1'b1; end
            OP_SRAV:  begin
                ctl.sel = SEL_SHIFT; ctl.sh_var = 1'b1;
                ctl.sh_right = 1'b1; ctl.sh_arith = 1'b1;
            end
            default:  ctl = '{sel: SEL_ZERO, default: 1'b0};
        endcase
    end

    int_exec_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .reg_b_i      (src_b_i),
        .imm_i        (imm_i),
        .use_imm_i    (ctl.use_imm),
        .imm_signed_i (ctl.imm_signed),
        .opnd_o       (opnd_b)
    );

    int_exec_arith #(.DATA_W(DATA_W)) u_arith (
        .a_i           (src_a_i),
        .b_i           (opnd_b),
        .subtract_i    (ctl.subtract),
        .sum_o         (sum),
        .sovf_o        (sovf),
        .lt_signed_o   (lt_s),
        .lt_unsigned_o (lt_u)
    );

    // Shift count: low bits of src_b for variable forms, else the constant.
    always_comb begin
        sh_amt = ctl.sh_var ? src_b_i[SH_W-1:0] : shamt_i;
    end

    int_exec_shift #(.DATA_W(DATA_W)) u_shift (
        .val_i   (src_a_i),
        .amt_i   (sh_amt),
        .right_i (ctl.sh_right),
        .arith_i (ctl.sh_arith),
        .res_o   (sh_res)
    );

    // Result multiplexer and trap outputs.
    always_comb begin
        unique case (ctl.sel)
            SEL_ARITH: result_o = sum;
            SEL_AND:   result_o = src_a_i & opnd_b;
            SEL_OR:    result_o = src_a_i | opnd_b;
            SEL_XOR:   result_o = src_a_i ^ opnd_b;
            SEL_NOR:   result_o = ~(src_a_i | opnd_b);
            SEL_SLT:   result_o = {{(DATA_W-1){1'b0}}, lt_s};
            SEL_SLTU:  result_o = {{(DATA_W-1){1'b0}}, lt_u};
            SEL_SHIFT: result_o = sh_res;
            SEL_UPPER: result_o = {imm_i, {LOW_W{1'b0}}};
            default:   result_o = '0;
        endcase
        ovf_o         = ctl.trap & sovf;
        wr_suppress_o = ctl.trap & sovf;
    end
endmodule

// File: rtl/int_exec_unit_chk.sv
// Assertion checker for int_exec_unit, attached with bind. Uses immediate
// assertions because the unit has no clock; each waits until the inputs
// carry known values.
module int_exec_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int OPC_W  = 5
) (
    input logic [OPC_W-1:0]  op_i,
    input logic [DATA_W-1:0] src_a_i,
    input logic [DATA_W-1:0] src_b_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [DATA_W-1:0] result_o,
    input logic              ovf_o,
    input logic              wr_suppress_o
);
    import int_exec_pkg::*;

    localparam int MSB = DATA_W - 1;

    logic known;
    logic is_trap;

    // Evaluate all properties whenever inputs or outputs change.
    always_comb begin
        known   = !$isunknown({op_i, src_a_i, src_b_i, imm_i});
        is_trap = (op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_ADDI);
        if (known) begin
            if (op_i == OP_ADD) begin
                p_ovf_add_r1: assert (ovf_o == ((src_a_i[MSB] == src_b_i[MSB]) &&
                                                (result_o[MSB] != src_a_i[MSB])));
            end
            if (op_i == OP_SUB) begin
                p_ovf_sub_r1: assert (ovf_o == ((src_a_i[MSB] != src_b_i[MSB]) &&
                                                (result_o[MSB] != src_a_i[MSB])));
            end
            if (ovf_o) begin
                p_ovf_add_wraps_r12: assert (op_i != OP_ADD || result_o == src_a_i + src_b_i);
            end
            if ((op_i == OP_ADDU) || (op_i == OP_SUBU) || (op_i == OP_ADDIU)) begin
                p_no_overflow_r2: assert (!ovf_o);
            end
            if (!is_trap) begin
                p_no_overflow_r3: assert (!ovf_o && !wr_suppress_o);
            end
            if ((op_i == OP_SLT) || (op_i == OP_SLTI)) begin
                p_bool_slt_r6: assert (result_o[MSB:1] == '0);
            end
            if ((op_i == OP_SLTU) || (op_i == OP_SLTIU)) begin
                p_bool_sltu_r7: assert (result_o[MSB:1] == '0);
            end
            if (op_i == OP_LUI) begin
                p_upper_imm_r11: assert (result_o == {imm_i, {(DATA_W-IMM_W){1'b0}}});
            end
            if (op_i > OP_SRAV) begin
                p_reserved_zero_r13: assert (result_o == '0 && !ovf_o);
            end
        end
    end
endmodule

bind int_exec_unit int_exec_unit_chk #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .OPC_W  (OPC_W)
) u_chk (
    .op_i          (op_i),
    .src_a_i       (src_a_i),
    .src_b_i       (src_b_i),
    .imm_i         (imm_i),
    .result_o      (result_o),
    .ovf_o         (ovf_o),
    .wr_suppress_o (wr_suppress_o)
);

// File: tb/tb_int_exec_unit.sv
// Directed bench for int_exec_unit: one task per scenario.
module tb_int_exec_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op;
    logic [31:0] a, b;
    logic [15:0] imm;
    logic [4:0]  shamt;
    logic [31:0] res;
    logic        ovf, sup;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_exec_unit dut (
        .op_i          (op),
        .src_a_i       (a),
        .src_b_i       (b),
        .imm_i         (imm),
        .shamt_i       (shamt),
        .result_o      (res),
        .ovf_o         (ovf),
        .wr_suppress_o (sup)
    );

    // Apply one operation at a falling edge and compare mid-cycle.
    task automatic run(input string req, input logic [4:0] o, input logic [31:0] va,
                       input logic [31:0] vb, input logic [15:0] vi, input logic [4:0] vs,
                       input logic [31:0] exp_res, input logic exp_ovf);
        @(negedge clk);
        op = o; a = va; b = vb; imm = vi; shamt = vs;
        #(CLK_PERIOD/4);
        checks++;
        if (res !== exp_res || ovf !== exp_ovf || sup !== exp_ovf) begin
            fails++;
            $display("FAIL %s op=%0d res=%h exp=%h ovf=%b sup=%b exp_ovf=%b",
                     req, o, res, exp_res, ovf, sup, exp_ovf);
        end
    endtask

    task automatic t_reset_state;
        run("R1", 5'd0, 32'h0, 32'h0, 16'h0, 5'd0, 32'h0, 1'b0);
    endtask

    task automatic t_trap_r1;
        run("R1", 5'd0, 32'h7fffffff, 32'h1, 16'h0, 5'd0, 32'h80000000, 1'b1);
        run("R1", 5'd0, 32'hffffffff, 32'h1, 16'h0, 5'd0, 32'h0, 1'b0);
        run("R1", 5'd0, 32'h80000000, 32'h80000000, 16'h0, 5'd0, 32'h0, 1'b1);
        run("R1", 5'd2, 32'h80000000, 32'h1, 16'h0, 5'd0, 32'h7fffffff, 1'b1);
        run("R1", 5'd2, 32'h5, 32'h7, 16'h0, 5'd0, 32'hfffffffe, 1'b0);
        run("R1", 5'd2, 32'h7fffffff, 32'hffffffff, 16'h0, 5'd0, 32'h80000000, 1'b1);
        run("R1", 5'd10, 32'h7fffffff, 32'h0, 16'h0001, 5'd0, 32'h80000000, 1'b1);
        run("R1", 5'd10, 32'h80000000, 32'h0, 16'hffff, 5'd0, 32'h7fffffff, 1'b1);
    endtask

    task automatic t_nontrap_r2;
        run("R2", 5'd1, 32'h7fffffff, 32'h1, 16'h0, 5'd0, 32'h80000000, 1'b0);
        run("R2", 5'd3, 32'h80000000, 32'h1, 16'h0, 5'd0, 32'h7fffffff, 1'b0);
        run("R2", 5'd11, 32'h80000000, 32'h0, 16'hffff, 5'd0, 32'h7fffffff, 1'b0);
    endtask

    task automatic t_zero_ext_r4;
        run("R4", 5'd14, 32'hffffffff, 32'h0, 16'h8001, 5'd0, 32'h00008001, 1'b0);
        run("R4", 5'd15, 32'h0, 32'h0, 16'hffff, 5'd0, 32'h0000ffff, 1'b0);
        run("R4", 5'd16, 32'hffff0000, 32'h0, 16'hffff, 5'd0, 32'hffffffff, 1'b0);
    endtask

    task automatic t_sign_ext_r5;
        run("R5", 5'd11, 32'h10, 32'h0, 16'hfffe, 5'd0, 32'h0000000e, 1'b0);
        run("R5", 5'd12, 32'hfffffffe, 32'h0, 16'hffff, 5'd0, 32'h1, 1'b0);
        run("R5", 5'd13, 32'h5, 32'h0, 16'hffff, 5'd0, 32'h1, 1'b0);
    endtask

    task automatic t_slt_r6;
        run("R6", 5'd8, 32'hffffffff, 32'h1, 16'h0, 5'd0, 32'h1, 1'b0);
        run("R6", 5'd8, 32'h1, 32'hffffffff, 16'h0, 5'd0, 32'h0, 1'b0);
        run("R6", 5'd8, 32'h1234, 32'h1234, 16'h0, 5'd0, 32'h0, 1'b0);
        run("R6", 5'd8, 32'h80000000, 32'h7fffffff, 16'h0, 5'd0, 32'h1, 1'b0);
        run("R6", 5'd12, 32'h3, 32'h0, 16'h0004, 5'd0, 32'h1, 1'b0);
    endtask

    task automatic t_sltu_r7;
        run("R7", 5'd9, 32'hffffffff, 32'h1, 16'h0, 5'd0, 32'h0, 1'b0);
        run("R7", 5'd9, 32'h1, 32'hffffffff, 16'h0, 5'd0, 32'h1, 1'b0);
        run("R7", 5'd9, 32'h9, 32'h9, 16'h0, 5'd0, 32'h0, 1'b0);
        run("R7", 5'd13, 32'hffffffff, 32'h0, 16'h0001, 5'd0, 32'h0, 1'b0);
    endtask

    task automatic t_logic_r8;
        run("R8", 5'd4, 32'hf0f0f0f0, 32'hff00ff00, 16'h0, 5'd0, 32'hf000f000, 1'b0);
        run("R8", 5'd5, 32'hf0f0f0f0, 32'hff00ff00, 16'h0, 5'd0, 32'hfff0fff0, 1'b0);
        run("R8", 5'd6, 32'hf0f0f0f0, 32'hff00ff00, 16'h0, 5'd0, 32'h0ff00ff0, 1'b0);
        run("R8", 5'd7, 32'hf0f0f0f0, 32'hff00ff00, 16'h0, 5'd0, 32'h000f000f, 1'b0);
    endtask

    task automatic t_const_shift_r9;
        run("R9", 5'd18, 32'h1, 32'h3, 16'h0, 5'd31, 32'h80000000, 1'b0);
        run("R9", 5'd19, 32'h80000000, 32'h1f, 16'h0, 5'd4, 32'h08000000, 1'b0);
        run("R9", 5'd20, 32'h80000000, 32'h1f, 16'h0, 5'd4, 32'hf8000000, 1'b0);
        run("R9", 5'd20, 32'h40000000, 32'h0, 16'h0, 5'd30, 32'h1, 1'b0);
        run("R9", 5'd18, 32'hdeadbeef, 32'h7, 16'h0, 5'd0, 32'hdeadbeef, 1'b0);
    endtask

    task automatic t_var_shift_r10;
        run("R10", 5'd21, 32'h1, 32'h25, 16'h0, 5'd9, 32'h20, 1'b0);
        run("R10", 5'd23, 32'h80000000, 32'hffffffe1, 16'h0, 5'd0, 32'hc0000000, 1'b0);
        run("R10", 5'd22, 32'hffffffff, 32'h1f, 16'h0, 5'd2, 32'h1, 1'b0);
        run("R10", 5'd22, 32'h80000000, 32'hffffff00, 16'h0, 5'd8, 32'h80000000, 1'b0);
    endtask

    task automatic t_upper_r11;
        run("R11", 5'd17, 32'hffffffff, 32'hffffffff, 16'habcd, 5'd3, 32'habcd0000, 1'b0);
        run("R11", 5'd17, 32'h0, 32'h0, 16'h0001, 5'd0, 32'h00010000, 1'b0);
    endtask

    task automatic t_suppress_r12;
        run("R12", 5'd0, 32'h40000000, 32'h40000000, 16'h0, 5'd0, 32'h80000000, 1'b1);
        run("R12", 5'd10, 32'h0, 32'h0, 16'h8000, 5'd0, 32'hffff8000, 1'b0);
    endtask

    task automatic t_reserved_r13;
        for (int c = 24; c < 32; c++) begin
            run("R13", 5'(c), 32'h7fffffff, 32'h7fffffff, 16'hffff, 5'd7, 32'h0, 1'b0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        op = '0; a = '0; b = '0; imm = '0; shamt = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_trap_r1();
        t_nontrap_r2();
        t_zero_ext_r4();
        t_sign_ext_r5();
        t_slt_r6();
        t_sltu_r7();
        t_logic_r8();
        t_const_shift_r9();
        t_var_shift_r10();
        t_upper_r11();
        t_suppress_r12();
        t_reserved_r13();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule